// File: doc/BRIEF.md
# Serial Control-Register Target

This block is a two-wire serial bus target that lets a host controller set and read back a small bank of control registers. Each register is reached through one 16-bit control word, sent most significant bit first. The upper seven bits select the register and the lower nine bits carry its value. The bus lines pass through two-flop synchronisers onto the system clock. The block answers on the SDA line only by pulling it low.

The register values are presented in parallel to the surrounding core. The core also feeds four status flags back into one read-only register. One write-only register restores every register to its power-on value. A read first sends the register number in a one-byte write phase, then a repeated START with the read flag, after which the target returns the value as two bytes.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, register 0x0A holds 0x02B, register 0x0B holds 0x04B, every other register holds 0, and SDA is released.
- R2: Only the 7-bit device address 0x3B is acknowledged (address byte 0x76 for write, 0x77 for read, LSB is the read flag, 1 = read). Any other address gets no ACK, and the bytes that follow it get no ACK and change nothing.
- R3: A write is START, 0x76, then two bytes forming the word {register[6:0], value[8:0]}. The target ACKs each byte and commits the value once the 16th bit has arrived.
- R4: Only implemented bits are stored, and all others read as 0. Register 0x00 and register 0x0C keep bits 6:0. Registers 0x01–0x07 keep bits 4:0. Register 0x0A keeps bits 5:0. Registers 0x08, 0x09, 0x0B, 0x0D and 0x0E keep bits 7:0.
- R5: A read is START, 0x76, the byte {register, 0}, a repeated START, then 0x77. The target returns the byte {7'b0, value[8]} followed by the byte value[7:0], each MSB first.
- R6: Register 0x0F reads as {5'b0, statusIn[3:0]}, and writes to it change nothing.
- R7: Register 0x10 reads as 0. Writing it with value bit 0 set restores every register to its reset value, and writing it with bit 0 clear changes nothing.
- R8: Writes to registers above 0x10 are acknowledged but change nothing, and reads from them return zeros.
- R9: A STOP aborts the transfer at any point. A word that is incomplete when the STOP arrives is discarded.
- R10: After the 16-bit word, further written bytes get no ACK and change nothing. After the second read byte, the target releases SDA, so any further byte reads 0xFF.
- R11: The target begins pulling SDA low only while SCL is low.
- R12: If the controller NACKs the first read byte, the target stops driving, and the next byte clocked reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | 1 pulls the data line low, 0 releases it |
| statusIn | input | 4 | Core status flags shown in register 0x0F |
| regsOut | output | 153 | Register values, register n at bits [9n+8:9n]; slots 0x0F and 0x10 are zero |

## Verification
Committing a control word and a bus condition (STOP or repeated START) are the two actions that meet at the end of a transfer. A word commits on the SCL fall that follows its 16th bit, while a STOP or START can arrive on any SCL-high phase, including one that falls straight after the first data byte. The bench ends transfers after one data byte, after a full word, after an extra byte, and by a repeated START in mid-word. For each case it judges from the register outputs and from the read-back bytes whether exactly the complete words took effect.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 9;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 17;
  localparam int STATUS_W = 4;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = 7'h0F;
  localparam logic [ADDR_W-1:0] SOFT_ADDR   = 7'h10;

  typedef struct packed {
    logic shiftIn;
    logic capPtr;
    logic wrWord;
    logic loadTxHi;
    logic loadTxLo;
    logic shiftTx;
  } strobes_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_HI, ST_HI_ACK, ST_LO, ST_LO_ACK,
    ST_TX_HI, ST_TX_LO, ST_MACK_HI, ST_MACK_LO, ST_SKIP
  } state_t;

  function automatic logic [DATA_W-1:0] regMask(input logic [ADDR_W-1:0] a);
    case (a)
      7'h00, 7'h0C:                      return 9'h07F;
      7'h01, 7'h02, 7'h03, 7'h04,
      7'h05, 7'h06, 7'h07:               return 9'h01F;
      7'h0A:                             return 9'h03F;
      7'h08, 7'h09, 7'h0B, 7'h0D, 7'h0E: return 9'h0FF;
      default:                           return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regDefault(input logic [ADDR_W-1:0] a);
    case (a)
      7'h0A:   return 9'h02B;
      7'h0B:   return 9'h04B;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_ctl_fsm.sv
module i2c_ctl_fsm
  import i2c_ctl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3B,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic             txMsb,
  output strobes_t         str,
  output logic             sdaBit,
  output logic             sdaLow
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;

  state_t state;
  logic [CNT_W-1:0] bitCnt;
  logic byteDone, ackDrive, isRead, mNack, txActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  assign txActive = (state == ST_TX_HI) || (state == ST_TX_LO);
  assign sdaLow   = ackDrive | (txActive & ~txMsb);

  always_comb begin
    str = '0;
    if (!(startDet || stopDet)) begin
      case (state)
        ST_ADDR, ST_HI, ST_LO: begin
          str.shiftIn = sclRise;
          if (sclFall && byteDone) begin
            str.capPtr = (state == ST_HI);
            str.wrWord = (state == ST_LO);
          end
        end
        ST_ADDR_ACK:        str.loadTxHi = sclFall && isRead;
        ST_TX_HI, ST_TX_LO: str.shiftTx  = sclFall && (bitCnt != LAST_BIT);
        ST_MACK_HI:         str.loadTxLo = sclFall && !mNack;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      ackDrive <= 1'b0;
      isRead   <= 1'b0;
      mNack    <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      byteDone <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_HI, ST_LO: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) byteDone <= 1'b1;
          end else if (sclFall && byteDone) begin
            byteDone <= 1'b0;
            bitCnt   <= '0;
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                ackDrive <= 1'b1;
                isRead   <= rxByte[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              ackDrive <= 1'b1;
              state    <= (state == ST_HI) ? ST_HI_ACK : ST_LO_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_HI_ACK, ST_LO_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            case (state)
              ST_ADDR_ACK: state <= isRead ? ST_TX_HI : ST_HI;
              ST_HI_ACK:   state <= ST_LO;
              default:     state <= ST_SKIP;
            endcase
          end
        end
        ST_TX_HI, ST_TX_LO: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              state  <= (state == ST_TX_HI) ? ST_MACK_HI : ST_MACK_LO;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_MACK_HI, ST_MACK_LO: begin
          if (sclRise) mNack <= sdaS;
          else if (sclFall)
            state <= (state == ST_MACK_HI && !mNack) ? ST_TX_LO : ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  // R11: a new pull-down only starts during SCL low
  p_sda_grab_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow && !$past(sdaLow)) |-> !sclS);

  // R9: STOP returns the machine to idle with the line released
  p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaLow));

  // R2: START rearms address reception
  p_start_rearms_r2: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == '0));

  // R2: a foreign address is never acknowledged
  p_foreign_no_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && byteDone && !startDet && !stopDet &&
     rxByte[BYTE_W-1:1] != DEV_ADDR) |=> (state == ST_SKIP && !sdaLow));

  // R3: at most one datapath action per cycle
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.shiftIn, str.capPtr, str.wrWord, str.loadTxHi, str.loadTxLo, str.shiftTx}));

endmodule

// File: rtl/i2c_ctl_datapath.sv
module i2c_ctl_datapath
  import i2c_ctl_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int DW   = DATA_W,
  parameter int SW   = STATUS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           str,
  input  logic               sdaBit,
  input  logic [SW-1:0]      statusIn,
  output logic [NREG*DW-1:0] regsOut,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               txMsb
);

  localparam int NUM_RW = int'(STATUS_ADDR);

  logic [BYTE_W-1:0] rxShift, txShift;
  logic [ADDR_W-1:0] ptr;
  logic              hiBit;
  logic [DW-1:0]     bank [NUM_RW];
  logic [DW-1:0]     wrData, readVal;
  logic              softHit;

  assign wrData  = {hiBit, rxShift};
  assign softHit = str.wrWord && (ptr == SOFT_ADDR) && wrData[0];
  assign rxByte  = rxShift;
  assign txMsb   = txShift[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptr     <= '0;
      hiBit   <= 1'b0;
    end else begin
      if (str.shiftIn)  rxShift <= {rxShift[BYTE_W-2:0], sdaBit};
      if (str.capPtr) begin
        ptr   <= rxShift[BYTE_W-1:1];
        hiBit <= rxShift[0];
      end
      if (str.loadTxHi) txShift <= {{(BYTE_W-1){1'b0}}, readVal[DW-1]};
      if (str.loadTxLo) txShift <= readVal[BYTE_W-1:0];
      if (str.shiftTx)  txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i < NUM_RW) begin : g_rw
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
      always_ff @(posedge clk) begin
        if (!rstN || softHit)
          bank[i] <= regDefault(IDX);
        else if (str.wrWord && ptr == IDX)
          bank[i] <= wrData & regMask(IDX);
      end
      assign regsOut[i*DW +: DW] = bank[i];
    end else begin : g_fixed
      assign regsOut[i*DW +: DW] = '0;
    end
  end

  always_comb begin
    readVal = '0;
    if (ptr == STATUS_ADDR) readVal = DW'(statusIn);
    for (int k = 0; k < NUM_RW; k++)
      if (ptr == ADDR_W'(k)) readVal = bank[k];
  end

  function automatic logic [NREG*DW-1:0] defaultFlat();
    logic [NREG*DW-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_RW; k++) v[k*DW +: DW] = regDefault(ADDR_W'(k));
    return v;
  endfunction

  // R7: a soft reset write restores every register
  p_soft_defaults_r7: assert property (@(posedge clk) disable iff (!rstN)
    softHit |=> (regsOut == defaultFlat()));

  // R6: status register writes leave the bank alone
  p_status_ro_r6: assert property (@(posedge clk) disable iff (!rstN)
    (str.wrWord && ptr == STATUS_ADDR) |=> $stable(regsOut));

  // R8: writes beyond the map leave the bank alone
  p_beyond_map_r8: assert property (@(posedge clk) disable iff (!rstN)
    (str.wrWord && ptr > SOFT_ADDR) |=> $stable(regsOut));

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs #(
  parameter logic [6:0] DEV_ADDR    = 7'h3B,
  parameter int         SYNC_STAGES = 2,
  parameter int         NREG        = 17,
  parameter int         DW          = 9,
  parameter int         SW          = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullLow,
  input  logic [SW-1:0]      statusIn,
  output logic [NREG*DW-1:0] regsOut
);

  i2c_ctl_pkg::strobes_t str;
  logic [i2c_ctl_pkg::BYTE_W-1:0] rxByte;
  logic txMsb, sdaBit;

  i2c_ctl_fsm #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .str(str), .sdaBit(sdaBit), .sdaLow(sdaPullLow)
  );

  i2c_ctl_datapath #(.NREG(NREG), .DW(DW), .SW(SW)) data_i (
    .clk(clk), .rstN(rstN), .str(str), .sdaBit(sdaBit), .statusIn(statusIn),
    .regsOut(regsOut), .rxByte(rxByte), .txMsb(txMsb)
  );

endmodule

// File: tb/i2c_ctl_regs_tb_top.sv
module i2c_ctl_regs_tb_top;

  localparam int T = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaPullLow;
  logic [3:0] statusIn = 4'h0;
  logic [152:0] regsOut;
  wire sdaLine = sdaDrv & ~sdaPullLow;

  i2c_ctl_regs dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .statusIn(statusIn), .regsOut(regsOut)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int expV[$];
  string expT[$];
  int obsV[$];

  task automatic expectItem(string tag, int v);
    expV.push_back(v);
    expT.push_back(tag);
  endtask

  // scoreboard monitor
  initial forever begin
    wait (obsV.size() != 0);
    begin
      int a, e;
      string t;
      a = obsV.pop_front();
      e = expV.pop_front();
      t = expT.pop_front();
      checks++;
      if (a != e) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  int r11Bad = 0;
  logic prevLow = 1'b0;
  always @(negedge clk) begin
    if (sdaPullLow && !prevLow && sclDrv) r11Bad++;
    prevLow <= sdaPullLow;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaDrv = 1'b0; tick(T); sclDrv = 1'b0; tick(T);
  endtask

  task automatic i2cRestart();
    sdaDrv = 1'b1; tick(T); sclDrv = 1'b1; tick(T);
    sdaDrv = 1'b0; tick(T); sclDrv = 1'b0; tick(T);
  endtask

  task automatic i2cStop();
    sdaDrv = 1'b0; tick(T); sclDrv = 1'b1; tick(T); sdaDrv = 1'b1; tick(2*T);
  endtask

  task automatic sendByte(string tag, logic [7:0] b, int expAck);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; tick(T); sclDrv = 1'b1; tick(2*T); sclDrv = 1'b0; tick(T);
    end
    sdaDrv = 1'b1; tick(T); sclDrv = 1'b1; tick(T);
    expectItem({tag, " ack"}, expAck);
    obsV.push_back(int'(sdaLine));
    tick(T); sclDrv = 1'b0; tick(T);
  endtask

  task automatic recvByte(string tag, int expB, bit nack);
    logic [7:0] b;
    b = '0;
    sdaDrv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(T); sclDrv = 1'b1; tick(T); b = {b[6:0], sdaLine}; tick(T); sclDrv = 1'b0; tick(T);
    end
    expectItem({tag, " byte"}, expB);
    obsV.push_back(int'(b));
    sdaDrv = nack; tick(T); sclDrv = 1'b1; tick(2*T); sclDrv = 1'b0; tick(T);
    sdaDrv = 1'b1;
  endtask

  task automatic chkReg(string tag, int a, int e);
    expectItem(tag, e);
    obsV.push_back(int'(regsOut[a*9 +: 9]));
  endtask

  task automatic wrReg(string tag, logic [6:0] a, logic [8:0] d);
    logic [15:0] w;
    w = {a, d};
    i2cStart();
    sendByte(tag, 8'h76, 0);
    sendByte(tag, w[15:8], 0);
    sendByte(tag, w[7:0], 0);
    i2cStop();
  endtask

  task automatic rdSetup(string tag, logic [6:0] a);
    i2cStart();
    sendByte(tag, 8'h76, 0);
    sendByte(tag, {a, 1'b0}, 0);
    i2cRestart();
    sendByte(tag, 8'h77, 0);
  endtask

  task automatic rdReg(string tag, logic [6:0] a, int expHi, int expLo);
    rdSetup(tag, a);
    recvByte(tag, expHi, 1'b0);
    recvByte(tag, expLo, 1'b1);
    i2cStop();
  endtask

  initial begin
    tick(5); rstN = 1'b1; tick(5);

    // R1 reset state
    chkReg("R1 reg0A", 8'h0A, 'h2B);
    chkReg("R1 reg0B", 8'h0B, 'h4B);
    chkReg("R1 reg00", 8'h00, 0);
    expectItem("R1 sda released", 0); obsV.push_back(int'(sdaPullLow));

    // R3 plain writes
    wrReg("R3 wr01", 7'h01, 9'h01F);
    chkReg("R3 reg01", 1, 'h1F);
    wrReg("R3 wr08", 7'h08, 9'h0A5);
    chkReg("R3 reg08", 8, 'hA5);

    // R4 masks
    wrReg("R4 wr01", 7'h01, 9'h0E5);
    chkReg("R4 reg01", 1, 'h05);
    wrReg("R4 wr00", 7'h00, 9'h1FF);
    chkReg("R4 reg00", 0, 'h7F);

    // R5 read back
    rdReg("R5 rd08", 7'h08, 'h00, 'hA5);

    // R2 foreign address
    i2cStart();
    sendByte("R2 foreign addr", 8'hA0, 1);
    sendByte("R2 foreign data", 8'h02, 1);
    sendByte("R2 foreign data", 8'h1F, 1);
    i2cStop();
    i2cStart();
    sendByte("R2 near addr", 8'h74, 1);
    i2cStop();
    chkReg("R2 reg01 kept", 1, 'h05);

    // R6 status register
    statusIn = 4'hA;
    rdReg("R6 rd0F", 7'h0F, 'h00, 'h0A);
    wrReg("R6 wr0F", 7'h0F, 9'h1FF);
    rdReg("R6 rd0F again", 7'h0F, 'h00, 'h0A);

    // R8 beyond the map
    wrReg("R8 wr20", 7'h20, 9'h0FF);
    chkReg("R8 reg08 kept", 8, 'hA5);
    rdReg("R8 rd20", 7'h20, 'h00, 'h00);

    // R9 STOP after first data byte discards the word
    begin
      logic [15:0] w;
      w = {7'h02, 9'h015};
      i2cStart();
      sendByte("R9 part", 8'h76, 0);
      sendByte("R9 part", w[15:8], 0);
      i2cStop();
      chkReg("R9 reg02 kept", 2, 0);
    end

    // R10 extra byte after the word, and extra read byte
    begin
      logic [15:0] w;
      w = {7'h03, 9'h011};
      i2cStart();
      sendByte("R10 wr", 8'h76, 0);
      sendByte("R10 wr", w[15:8], 0);
      sendByte("R10 wr", w[7:0], 0);
      sendByte("R10 extra", 8'hFF, 1);
      i2cStop();
      chkReg("R10 reg03", 3, 'h11);
      rdSetup("R10 rd", 7'h03);
      recvByte("R10 rd hi", 'h00, 1'b0);
      recvByte("R10 rd lo", 'h11, 1'b0);
      recvByte("R10 rd extra", 'hFF, 1'b1);
      i2cStop();
    end

    // R12 NACK of first read byte
    rdSetup("R12 rd", 7'h08);
    recvByte("R12 hi", 'h00, 1'b1);
    recvByte("R12 after nack", 'hFF, 1'b1);
    i2cStop();

    // R7 write-only soft reset register
    rdReg("R7 rd10", 7'h10, 'h00, 'h00);
    wrReg("R7 wr10 bit0 clear", 7'h10, 9'h000);
    chkReg("R7 reg08 kept", 8, 'hA5);
    wrReg("R7 wr10 bit0 set", 7'h10, 9'h001);
    chkReg("R7 reg08 default", 8, 0);
    chkReg("R7 reg01 default", 1, 0);
    chkReg("R7 reg0A default", 8'h0A, 'h2B);

    tick(20);
    expectItem("R11 pull start during SCL high", 0); obsV.push_back(r11Bad);
    wait (obsV.size() == 0);
    tick(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule